// File: doc/BRIEF.md
# FIFO-Buffered SPI Master

This block is a full-duplex SPI master. Words written by the host go into a transmit queue. Whenever that queue holds a word, the shift engine sends it most significant bit first, one bit on `mosi` per SCK period, and at the same time collects one bit per period from `miso`. After the last bit of a word the collected word is pushed into a receive queue, and the host pops it from there. Both queues have a fixed byte budget, so the number of words they can hold depends on the selected word size of 8, 16 or 32 bits.

The SCK rate comes from a 9-bit divider. Three settings shape the waveform: clock idle level, the edge on which output data changes, and whether input is sampled in the middle or at the end of a bit. Three level-sensitive interrupt lines report queue state through selectable threshold conditions, and receive overflow through a sticky flag. An optional automatic chip select stays asserted while transmit data remains or a word is still shifting. Clearing the enable input stops the engine and empties both queues.

Top module: `spi_fifo_master`

## Requirements
- R1: Each queue holds 16, 8 or 4 words for `cfg_width` codes 0, 1 and 2 (8-, 16- and 32-bit words); code 3 behaves as code 2. A write while the transmit queue is full, or while `cfg_en` is low, is dropped.
- R2: The engine starts a word only when the transmit queue is non-empty. It sends the word most significant bit first and pushes the received word into the receive queue after its last bit. Written bits above the word size are ignored, and received words are zero-extended.
- R3: Every bit lasts 2 x (`cfg_div` + 1) clock cycles, split into two equal halves. When no word is shifting, `sck` rests at `cfg_cpol`.
- R4: With `cfg_cke` = 1, `mosi` changes on the active-to-idle SCK edge and is steady at the idle-to-active edge. With `cfg_cke` = 0, it changes on the idle-to-active edge and is steady at the active-to-idle edge.
- R5: With `cfg_late_smp` = 0, `miso` is sampled at the end of the first half of each bit. With `cfg_late_smp` = 1, it is sampled at the end of the bit.
- R6: `irq_rx` follows `cfg_rx_mode`: 0 = receive queue empty, 1 = not empty, 2 = level of at least half the capacity, 3 = level equal to the capacity.
- R7: `irq_tx` follows `cfg_tx_mode`: 0 = transmit queue empty and no word shifting, 1 = transmit queue empty, 2 = at least half the capacity free, 3 = at least one entry free.
- R8: A word that completes while the receive queue is full is discarded, and the queue keeps its older contents. This sets `ovf_flag`, which stays set until `ovf_clr` is pulsed. `irq_fault` equals `ovf_flag` gated by `cfg_ovf_irq_en`.
- R9: With `cfg_auto_cs` = 1, `cs_n` is low while the transmit queue is non-empty or a word is shifting, and high otherwise. With `cfg_auto_cs` = 0, `cs_n` stays high.
- R10: While `cfg_en` is low, both levels read 0 on the following cycle, shifting stops and `sck` returns to `cfg_cpol`. After reset both queues are empty and no word is shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Engine enable; low flushes the queues |
| cfg_width | input | 2 | Word size code: 0 = 8, 1 = 16, 2 = 32 bits |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cke | input | 1 | 1 = data changes on active-to-idle edge |
| cfg_late_smp | input | 1 | 1 = sample at end of bit, 0 = at mid bit |
| cfg_div | input | 9 | SCK divider value |
| cfg_rx_mode | input | 2 | Receive interrupt condition select |
| cfg_tx_mode | input | 2 | Transmit interrupt condition select |
| cfg_auto_cs | input | 1 | Enable engine-driven chip select |
| cfg_ovf_irq_en | input | 1 | Route overflow to fault interrupt |
| wr_en | input | 1 | Push `wr_data` into the transmit queue |
| wr_data | input | 32 | Word to send, right-aligned |
| rd_en | input | 1 | Pop the receive queue head |
| rd_data | output | 32 | Receive queue head, zero-extended |
| ovf_clr | input | 1 | Clear the overflow flag |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Automatic chip select, active low |
| tx_level | output | 5 | Words in the transmit queue |
| rx_level | output | 5 | Words in the receive queue |
| irq_rx | output | 1 | Receive threshold interrupt |
| irq_tx | output | 1 | Transmit threshold interrupt |
| irq_fault | output | 1 | Fault interrupt |
| ovf_flag | output | 1 | Sticky receive overflow flag |

## Verification
Two corners are hard to reach: a full transmit queue, and the state where the queue is empty but a word is still shifting. Both exist only while the engine is slow. The bench therefore sets the largest divider, so one word occupies the shifter for thousands of cycles, and writes back-to-back during that window. The sample-point setting cannot be seen through a loopback, because `mosi` holds steady for the whole bit. The bench instead drives `miso` high in the first half of every bit and low in the second half, so a mid-bit sample returns all ones and an end-of-bit sample returns all zeros.

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int FIFO_BYTES = 16,
  parameter int DIV_W = 9,
  localparam int AW = $clog2(FIFO_BYTES),
  localparam int LW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [1:0]       cfg_width,
  input  logic             cfg_cpol,
  input  logic             cfg_cke,
  input  logic             cfg_late_smp,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [1:0]       cfg_rx_mode,
  input  logic [1:0]       cfg_tx_mode,
  input  logic             cfg_auto_cs,
  input  logic             cfg_ovf_irq_en,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  output logic [31:0]      rd_data,
  input  logic             ovf_clr,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             cs_n,
  output logic [LW-1:0]    tx_level,
  output logic [LW-1:0]    rx_level,
  output logic             irq_rx,
  output logic             irq_tx,
  output logic             irq_fault,
  output logic             ovf_flag
);

  logic [31:0] tx_mem [FIFO_BYTES];
  logic [31:0] rx_mem [FIFO_BYTES];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0] tx_cnt, rx_cnt;

  logic             busy, half;
  logic [DIV_W-1:0] div_cnt;
  logic [5:0]       bit_left;
  logic [31:0]      tx_sh, rx_sh;

  logic [1:0]    wsel;
  logic [5:0]    nbits;
  logic [LW-1:0] cap;

  assign wsel  = (cfg_width == 2'd0) ? 2'd0 : (cfg_width == 2'd1) ? 2'd1 : 2'd2;
  assign nbits = 6'd8 << wsel;
  assign cap   = LW'(FIFO_BYTES) >> wsel;

  logic tx_push, tx_pop, rx_pop, half_end, end_pt, word_done, rx_push, ovf_set;
  logic [31:0] rx_word;

  assign tx_push   = wr_en && cfg_en && (tx_cnt < cap);
  assign tx_pop    = cfg_en && !busy && (tx_cnt != '0);
  assign rx_pop    = rd_en && cfg_en && (rx_cnt != '0);
  assign half_end  = busy && (div_cnt == cfg_div);
  assign end_pt    = half_end && half;
  assign word_done = end_pt && (bit_left == 6'd1);
  assign rx_word   = (end_pt && cfg_late_smp) ? {rx_sh[30:0], miso} : rx_sh;
  assign rx_push   = word_done && (rx_cnt < cap);
  assign ovf_set   = word_done && (rx_cnt >= cap);

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= wr_data;
    if (rx_push) rx_mem[rx_wp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      busy <= 1'b0; half <= 1'b0; div_cnt <= '0; bit_left <= '0;
      tx_sh <= '0; rx_sh <= '0;
    end else if (!cfg_en) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      busy <= 1'b0; half <= 1'b0; div_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + LW'(tx_push) - LW'(tx_pop);
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + LW'(rx_push) - LW'(rx_pop);

      if (tx_pop) begin
        busy     <= 1'b1;
        half     <= 1'b0;
        div_cnt  <= '0;
        bit_left <= nbits;
        tx_sh    <= tx_mem[tx_rp] << (6'd32 - nbits);
        rx_sh    <= '0;
      end else if (busy) begin
        if (half_end) begin
          div_cnt <= '0;
          half    <= ~half;
          if (!half && !cfg_late_smp) rx_sh <= {rx_sh[30:0], miso};
          if (end_pt) begin
            if (cfg_late_smp) rx_sh <= {rx_sh[30:0], miso};
            tx_sh    <= tx_sh << 1;
            bit_left <= bit_left - 6'd1;
            if (bit_left == 6'd1) busy <= 1'b0;
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (ovf_set) ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  assign rd_data  = rx_mem[rx_rp];
  assign tx_level = tx_cnt;
  assign rx_level = rx_cnt;
  assign sck      = busy ? (cfg_cpol ^ (cfg_cke ? half : ~half)) : cfg_cpol;
  assign mosi     = busy & tx_sh[31];
  assign cs_n     = ~(cfg_auto_cs & (busy | (tx_cnt != '0)));

  always_comb begin
    case (cfg_rx_mode)
      2'd0:    irq_rx = (rx_cnt == '0);
      2'd1:    irq_rx = (rx_cnt != '0);
      2'd2:    irq_rx = (rx_cnt >= (cap >> 1));
      default: irq_rx = (rx_cnt == cap);
    endcase
    case (cfg_tx_mode)
      2'd0:    irq_tx = (tx_cnt == '0) && !busy;
      2'd1:    irq_tx = (tx_cnt == '0);
      2'd2:    irq_tx = ((cap - tx_cnt) >= (cap >> 1));
      default: irq_tx = (tx_cnt < cap);
    endcase
  end

  assign irq_fault = ovf_flag & cfg_ovf_irq_en;

endmodule

// File: rtl/spi_fifo_master_chk.sv
module spi_fifo_master_chk #(
  parameter int FIFO_BYTES = 16,
  localparam int LW = $clog2(FIFO_BYTES) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic [1:0]    cfg_width,
  input logic          cfg_cpol,
  input logic          cfg_auto_cs,
  input logic          ovf_clr,
  input logic          sck,
  input logic          cs_n,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          irq_fault,
  input logic          ovf_flag
);

  logic [LW-1:0] words;
  assign words = LW'(FIFO_BYTES) >> ((cfg_width == 2'd0) ? 0 : (cfg_width == 2'd1) ? 1 : 2);

  p_level_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= words) && (rx_level <= words));

  p_idle_sck_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto_cs && cs_n) |-> (sck == cfg_cpol));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  p_fault_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fault |-> ovf_flag);

  p_cs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto_cs && (tx_level != '0)) |-> !cs_n);

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> ((tx_level == '0) && (rx_level == '0)));

endmodule

bind spi_fifo_master spi_fifo_master_chk #(.FIFO_BYTES(FIFO_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_width(cfg_width),
  .cfg_cpol(cfg_cpol), .cfg_auto_cs(cfg_auto_cs), .ovf_clr(ovf_clr),
  .sck(sck), .cs_n(cs_n), .tx_level(tx_level), .rx_level(rx_level),
  .irq_fault(irq_fault), .ovf_flag(ovf_flag)
);

// File: tb/spi_fifo_master_bench.sv
module spi_fifo_master_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cfg_en = 0, cfg_cpol = 0, cfg_cke = 1, cfg_late = 0, cfg_auto_cs = 0, cfg_ovf_irq_en = 0;
  logic [1:0] cfg_width = 0, cfg_rx_mode = 0, cfg_tx_mode = 0;
  logic [8:0] cfg_div = 0;
  logic wr_en = 0, rd_en = 0, ovf_clr = 0, miso_sel = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic sck, mosi, cs_n, miso, irq_rx, irq_tx, irq_fault, ovf_flag;
  logic [4:0] tx_level, rx_level;

  assign miso = miso_sel ? (sck == (cfg_cpol ^ ~cfg_cke)) : mosi;

  spi_fifo_master u_spi_fifo_master (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_width(cfg_width),
    .cfg_cpol(cfg_cpol), .cfg_cke(cfg_cke), .cfg_late_smp(cfg_late),
    .cfg_div(cfg_div), .cfg_rx_mode(cfg_rx_mode), .cfg_tx_mode(cfg_tx_mode),
    .cfg_auto_cs(cfg_auto_cs), .cfg_ovf_irq_en(cfg_ovf_irq_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .ovf_clr(ovf_clr), .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .tx_level(tx_level), .rx_level(rx_level), .irq_rx(irq_rx),
    .irq_tx(irq_tx), .irq_fault(irq_fault), .ovf_flag(ovf_flag)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // serial monitor: captures mosi on the edge where it must be steady
  int cyc = 0, last_edge = 0, mon_n = 0, mon_cnt = 0, gap_err = 0;
  logic prev_sck = 0;
  logic [31:0] mon_sh = 0;
  logic [31:0] mon_words [64];

  function automatic int nb_of(input logic [1:0] w);
    return (w == 0) ? 8 : (w == 1) ? 16 : 32;
  endfunction
  function automatic logic [31:0] mask_of(input logic [1:0] w);
    return (w == 0) ? 32'hFF : (w == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!cfg_en) mon_n = 0;
    else if (sck !== prev_sck && sck == (cfg_cpol ^ cfg_cke)) begin
      if (mon_n != 0 && (cyc - last_edge) != 2 * (int'(cfg_div) + 1)) gap_err++;
      last_edge = cyc;
      mon_sh = {mon_sh[30:0], mosi};
      mon_n++;
      if (mon_n == nb_of(cfg_width)) begin
        mon_words[mon_cnt % 64] = mon_sh & mask_of(cfg_width);
        mon_cnt++;
        mon_n = 0;
      end
    end
    prev_sck = sck;
  end

  task automatic setup(input logic [1:0] w, input logic cpol, input logic cke,
                       input logic late, input logic [8:0] dv, input logic acs);
    @(negedge clk);
    cfg_en = 0;
    cfg_width = w; cfg_cpol = cpol; cfg_cke = cke; cfg_late = late;
    cfg_div = dv; cfg_auto_cs = acs;
    @(negedge clk);
    cfg_en = 1;
  endtask

  task automatic wait_rx(input int n);
    for (int i = 0; i < 20000 && rx_level != 5'(n); i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(tx_level == 0 && rx_level == 0, "R10 reset levels", {tx_level, rx_level}, 0);
    chk(cs_n == 1 && sck == 0, "R9 reset cs/sck", {cs_n, sck}, 2'b10);
    chk(irq_rx == 1, "R6 rx mode0 empty", irq_rx, 1);
    chk(irq_tx == 1, "R7 tx mode0 idle", irq_tx, 1);
    chk(irq_fault == 0 && ovf_flag == 0, "R8 reset fault", {irq_fault, ovf_flag}, 0);
  endtask

  task automatic t_loop(input logic [1:0] w, input logic cpol, input logic cke,
                        input logic [8:0] dv, input logic acs, input logic [31:0] a,
                        input logic [31:0] b, input logic [31:0] c);
    logic [31:0] words [3];
    int base;
    words[0] = a; words[1] = b; words[2] = c;
    miso_sel = 0;
    setup(w, cpol, cke, 0, dv, acs);
    base = mon_cnt;
    gap_err = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); wr_en = 1; wr_data = words[i];
    end
    @(negedge clk); wr_en = 0;
    chk(cs_n == !acs, "R9 cs during transfer", cs_n, !acs);
    wait_rx(3);
    chk(rx_level == 3, "R2 received count", rx_level, 3);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(rd_data == (words[i] & mask_of(w)), "R2 loopback word", rd_data, words[i] & mask_of(w));
      chk(mon_words[(base + i) % 64] == (words[i] & mask_of(w)), "R4 serial word on steady edge",
          mon_words[(base + i) % 64], words[i] & mask_of(w));
      rd_en = 1;
      @(negedge clk); rd_en = 0;
    end
    chk(gap_err == 0, "R3 bit period", gap_err, 0);
    repeat (4) @(negedge clk);
    chk(cs_n == 1, "R9 cs released", cs_n, 1);
    chk(sck == cpol, "R3 idle sck level", sck, cpol);
  endtask

  task automatic t_sample(input logic cke, input logic late);
    logic [31:0] exp;
    exp = late ? 32'h00 : 32'hFF;
    setup(0, 0, cke, late, 2, 0);
    miso_sel = 1;
    @(negedge clk); wr_en = 1; wr_data = 32'h5A;
    @(negedge clk); wr_en = 0;
    wait_rx(1);
    chk(rd_data == exp, late ? "R5 end sample" : "R5 mid sample", rd_data, exp);
    miso_sel = 0;
  endtask

  task automatic t_capacity(input logic [1:0] w);
    int cap;
    cap = 16 / (nb_of(w) / 8);
    setup(w, 1, 1, 0, 9'd511, 1);
    @(negedge clk); wr_en = 1; wr_data = 32'h1;
    @(negedge clk); wr_en = 0;
    repeat (3) @(negedge clk);
    cfg_tx_mode = 0; #1;
    chk(tx_level == 0 && irq_tx == 0, "R7 mode0 busy shifter", {tx_level, irq_tx}, 0);
    cfg_tx_mode = 1; #1;
    chk(irq_tx == 1, "R7 mode1 queue empty", irq_tx, 1);
    chk(tx_level == 0 && cs_n == 0, "R2/R9 shifting word holds cs", {tx_level, cs_n}, 0);
    for (int i = 0; i < cap + 3; i++) begin
      @(negedge clk); wr_en = 1; wr_data = 32'(i);
    end
    @(negedge clk); wr_en = 0;
    chk(tx_level == 5'(cap), "R1 transmit capacity", tx_level, cap);
    cfg_tx_mode = 3; #1;
    chk(irq_tx == 0, "R7 mode3 full", irq_tx, 0);
    cfg_tx_mode = 2; #1;
    chk(irq_tx == 0, "R7 mode2 full", irq_tx, 0);
    cfg_en = 0;
    @(negedge clk);
    chk(tx_level == 0 && rx_level == 0, "R10 flush on disable", {tx_level, rx_level}, 0);
    chk(sck == 1 && cs_n == 1, "R10 sck idle after disable", {sck, cs_n}, 2'b11);
    wr_en = 1; wr_data = 32'h3;
    @(negedge clk); wr_en = 0;
    chk(tx_level == 0, "R1 write while disabled dropped", tx_level, 0);
    cfg_tx_mode = 2; #1;
    chk(irq_tx == 1, "R7 mode2 empty", irq_tx, 1);
  endtask

  task automatic t_overflow;
    setup(0, 0, 1, 0, 0, 0);
    miso_sel = 0;
    cfg_ovf_irq_en = 1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); wr_en = 1; wr_data = 32'(8'h10 + i);
    end
    @(negedge clk); wr_en = 0;
    wait_rx(16);
    cfg_rx_mode = 3; #1;
    chk(irq_rx == 1, "R6 mode3 full", irq_rx, 1);
    chk(ovf_flag == 0, "R8 no overflow at exact fill", ovf_flag, 0);
    @(negedge clk); wr_en = 1; wr_data = 32'h77;
    @(negedge clk); wr_en = 0;
    repeat (40) @(negedge clk);
    chk(rx_level == 16, "R8 overflow word dropped", rx_level, 16);
    chk(ovf_flag == 1 && irq_fault == 1, "R8 overflow raises fault", {ovf_flag, irq_fault}, 2'b11);
    cfg_ovf_irq_en = 0; #1;
    chk(irq_fault == 0, "R8 fault gated", irq_fault, 0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk(rd_data == 32'(8'h10 + i), "R8 older contents kept", rd_data, 32'(8'h10 + i));
      rd_en = 1;
      @(negedge clk); rd_en = 0;
      #1;
      if (i == 7) begin
        cfg_rx_mode = 2; #1;
        chk(irq_rx == 1, "R6 mode2 at half", irq_rx, 1);
      end
      if (i == 8) begin
        cfg_rx_mode = 2; #1;
        chk(irq_rx == 0, "R6 mode2 below half", irq_rx, 0);
        cfg_rx_mode = 1; #1;
        chk(irq_rx == 1, "R6 mode1 not empty", irq_rx, 1);
      end
    end
    cfg_rx_mode = 1; #1;
    chk(irq_rx == 0, "R6 mode1 empty", irq_rx, 0);
    chk(ovf_flag == 1, "R8 flag sticky", ovf_flag, 1);
    @(negedge clk); ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
    chk(ovf_flag == 0, "R8 flag cleared", ovf_flag, 0);
    cfg_rx_mode = 0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_loop(0, 0, 1, 1, 1, 32'h1234_56A5, 32'h3C, 32'hF0);
    t_loop(1, 1, 0, 2, 0, 32'hBEEF, 32'h1234, 32'hFFFF_8001);
    t_loop(2, 0, 0, 0, 1, 32'hDEAD_BEEF, 32'h8000_0001, 32'h0F0F_5AA5);
    t_loop(3, 1, 1, 3, 1, 32'hC001_D00D, 32'h7, 32'hFFFF_FFFE);
    t_sample(0, 0);
    t_sample(0, 1);
    t_sample(1, 0);
    t_sample(1, 1);
    t_capacity(0);
    t_capacity(1);
    t_capacity(2);
    t_overflow();
    summary();
  end
endmodule